// File: doc/BRIEF.md
# Branch Condition Evaluator and Compare-Jump Pairing Checker

This decode-stage block looks at an ALU operation paired with the conditional jump that follows it. It does two things in one registered step. First, it works out whether that pair may issue as one combined internal operation, using one fixed pairing policy. Second, it computes the five condition flags that the ALU operation produces on a `DATA_W`-bit datapath, and evaluates the jump's condition code against those flags to give a taken or not-taken result.

The operation class arrives as a 4-bit code:

| Code | Operation | Notes |
|------|-----------|-------|
| 0 | TEST | flags only |
| 1 | AND | |
| 2 | OR | |
| 3 | XOR | |
| 4 | CMP | flags only |
| 5 | ADD | |
| 6 | SUB | |
| 7 | INC | |
| 8 | DEC | |
| 9 to 15 | unassigned | |

The condition code is also 4 bits. Bits [3:1] select a condition family:

| Value | Family | Condition |
|-------|--------|-----------|
| 0 | overflow | OF |
| 1 | below | CF |
| 2 | zero | ZF |
| 3 | below-or-equal | CF or ZF |
| 4 | sign | SF |
| 5 | parity | PF |
| 6 | less | SF xor OF |
| 7 | less-or-equal | (SF xor OF) or ZF |

When bit 0 is 1, the negated form of the family's condition is used. A carry input supplies the CF value that increment and decrement must keep unchanged. `DATA_W` must be at least 8.

Top module: `brcc_fuse_unit`

## Requirements
- R1: While reset is asserted, and until reset release has passed through the two-stage synchronizer, every output is 0.
- R2: A request is accepted on a rising edge where `in_valid` is 1, and all of its results appear one cycle later with `out_valid` set to 1. Edges where `in_valid` is 0 clear `out_valid` and leave `res`, `res_wr`, `fuse_ok`, `br_taken` and the flags unchanged.
- R3: `res` gives the operation result: a&b for TEST and AND, a|b for OR, a^b for XOR, a+b for ADD, a-b for CMP and SUB, a+1 for INC, a-1 for DEC, and 0 for codes 9 to 15. `res_wr` is 1 only for AND, OR, XOR, ADD, SUB, INC and DEC.
- R4: ZF is 1 when all `DATA_W` bits of the result are zero. SF equals the result MSB. PF is 1 when bits [7:0] of the result hold an even number of ones; the upper bits are ignored.
- R5: For ADD, CF is the unsigned carry out. For CMP and SUB, CF is the unsigned borrow (a < b). For all three, OF is 1 when the true signed result does not fit in `DATA_W` bits.
- R6: TEST, AND, OR and XOR force CF and OF to 0, whatever `cf_in` is.
- R7: INC and DEC set OF as ADD and SUB with an operand of 1 would. They pass `cf_in` through unchanged as CF.
- R8: `br_taken` is the family condition for cc[3:1] (0 OF, 1 CF, 2 ZF, 3 CF|ZF, 4 SF, 5 PF, 6 SF^OF, 7 (SF^OF)|ZF), computed from the flags of the same request.
- R9: When cc[0] is 1, `br_taken` is the inverse of the value that cc[0] = 0 would give.
- R10: TEST and AND may pair with every condition family (`fuse_ok` = 1).
- R11: OR and XOR never pair (`fuse_ok` = 0).
- R12: CMP, ADD and SUB pair only with families 1, 2, 3, 6 and 7; they never pair with 0, 4 or 5.
- R13: INC and DEC pair only with families 2, 6 and 7.
- R14: Codes 9 to 15 never pair, do not write, and give CF = OF = SF = 0 with ZF = PF = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation class code |
| cc | input | 4 | Condition code; bits [3:1] select the family, bit 0 negates |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand (ignored by INC and DEC) |
| cf_in | input | 1 | Current carry flag, kept by INC and DEC |
| out_valid | output | 1 | Results below belong to a request accepted last cycle |
| fuse_ok | output | 1 | The pair may issue as one operation |
| br_taken | output | 1 | The jump condition holds |
| res | output | DATA_W | Operation result |
| res_wr | output | 1 | The operation writes its result |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| pf_o | output | 1 | Parity flag |

## Verification
The assertions check these on every cycle:
- ZF, SF and PF stay consistent with the registered result.
- The logic operations clear CF and OF.
- INC and DEC carry the old CF through.
- OR and XOR never pair, and INC and DEC refuse the overflow, sign and parity families.
- The sign and zero families, and the negated sign family, follow the flags.
- Idle cycles hold the result.

The directed scenarios are needed for the arithmetic boundaries, such as signed overflow at the most-negative value, wrap to zero and borrow. They also cover the parity rule ignoring the upper byte. The scenarios sweep all sixteen condition codes against several compare outcomes, and all 256 entries of the pairing matrix.

// File: rtl/brcc_pkg.sv
package brcc_pkg;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned CC_W  = 4;
  localparam int unsigned FAM_N = 8;

  localparam logic [OPC_W-1:0] OPC_TEST = 4'd0;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_OR   = 4'd2;
  localparam logic [OPC_W-1:0] OPC_XOR  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_CMP  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_INC  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_DEC  = 4'd8;

  localparam logic [2:0] FAM_OVF    = 3'd0;
  localparam logic [2:0] FAM_BELOW  = 3'd1;
  localparam logic [2:0] FAM_ZERO   = 3'd2;
  localparam logic [2:0] FAM_BELEQ  = 3'd3;
  localparam logic [2:0] FAM_SIGN   = 3'd4;
  localparam logic [2:0] FAM_PAR    = 3'd5;
  localparam logic [2:0] FAM_LESS   = 3'd6;
  localparam logic [2:0] FAM_LESSEQ = 3'd7;

  // Pairing masks, bit i = family i may pair
  localparam logic [FAM_N-1:0] PAIR_ALL    = 8'hFF;
  localparam logic [FAM_N-1:0] PAIR_ARITH  = 8'hCE;
  localparam logic [FAM_N-1:0] PAIR_STEP   = 8'hC4;
  localparam logic [FAM_N-1:0] PAIR_NONE   = 8'h00;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } flags_t;
endpackage

// File: rtl/brcc_flag_gen.sv
module brcc_flag_gen
  import brcc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cf_in,
  output logic [DATA_W-1:0] res,
  output logic              res_wr,
  output flags_t            flg
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_z;
  logic [DATA_W:0]   dif_z;
  logic              add_ovf;
  logic              sub_ovf;

  always_comb begin
    b_eff   = ((op == OPC_INC) || (op == OPC_DEC)) ? DATA_W'(1) : opb;
    sum_z   = {1'b0, opa} + {1'b0, b_eff};
    dif_z   = {1'b0, opa} - {1'b0, b_eff};
    add_ovf = (opa[MSB] == b_eff[MSB]) && (sum_z[MSB] != opa[MSB]);
    sub_ovf = (opa[MSB] != b_eff[MSB]) && (dif_z[MSB] != opa[MSB]);
  end

  always_comb begin
    res    = '0;
    res_wr = 1'b0;
    flg.cf = 1'b0;
    flg.of = 1'b0;
    case (op)
      OPC_TEST: res = opa & opb;
      OPC_AND: begin
        res    = opa & opb;
        res_wr = 1'b1;
      end
      OPC_OR: begin
        res    = opa | opb;
        res_wr = 1'b1;
      end
      OPC_XOR: begin
        res    = opa ^ opb;
        res_wr = 1'b1;
      end
      OPC_CMP: begin
        res    = dif_z[MSB:0];
        flg.cf = dif_z[DATA_W];
        flg.of = sub_ovf;
      end
      OPC_ADD: begin
        res    = sum_z[MSB:0];
        res_wr = 1'b1;
        flg.cf = sum_z[DATA_W];
        flg.of = add_ovf;
      end
      OPC_SUB: begin
        res    = dif_z[MSB:0];
        res_wr = 1'b1;
        flg.cf = dif_z[DATA_W];
        flg.of = sub_ovf;
      end
      OPC_INC: begin
        res    = sum_z[MSB:0];
        res_wr = 1'b1;
        flg.cf = cf_in;
        flg.of = add_ovf;
      end
      OPC_DEC: begin
        res    = dif_z[MSB:0];
        res_wr = 1'b1;
        flg.cf = cf_in;
        flg.of = sub_ovf;
      end
      default: res = '0;
    endcase
    flg.zf = (res == '0);
    flg.sf = res[MSB];
    flg.pf = ~^res[7:0];
  end
endmodule

// File: rtl/brcc_cond_eval.sv
module brcc_cond_eval
  import brcc_pkg::*;
(
  input  flags_t          flg,
  input  logic [CC_W-1:0] cc,
  output logic            taken
);
  logic [FAM_N-1:0] fam_hit;

  always_comb begin
    fam_hit[FAM_OVF]    = flg.of;
    fam_hit[FAM_BELOW]  = flg.cf;
    fam_hit[FAM_ZERO]   = flg.zf;
    fam_hit[FAM_BELEQ]  = flg.cf | flg.zf;
    fam_hit[FAM_SIGN]   = flg.sf;
    fam_hit[FAM_PAR]    = flg.pf;
    fam_hit[FAM_LESS]   = flg.sf ^ flg.of;
    fam_hit[FAM_LESSEQ] = (flg.sf ^ flg.of) | flg.zf;
    taken = fam_hit[cc[CC_W-1:1]] ^ cc[0];
  end
endmodule

// File: rtl/brcc_pair_table.sv
module brcc_pair_table
  import brcc_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  input  logic [2:0]       fam,
  output logic             pair_ok
);
  logic [FAM_N-1:0] mask;

  always_comb begin
    case (op)
      OPC_TEST, OPC_AND:         mask = PAIR_ALL;
      OPC_CMP, OPC_ADD, OPC_SUB: mask = PAIR_ARITH;
      OPC_INC, OPC_DEC:          mask = PAIR_STEP;
      default:                   mask = PAIR_NONE;
    endcase
    pair_ok = mask[fam];
  end
endmodule

// File: rtl/brcc_fuse_unit.sv
module brcc_fuse_unit
  import brcc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [3:0]        cc,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cf_in,
  output logic              out_valid,
  output logic              fuse_ok,
  output logic              br_taken,
  output logic [DATA_W-1:0] res,
  output logic              res_wr,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              pf_o
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[RST_STAGES-1];

  logic [DATA_W-1:0] c_res;
  logic              c_wr;
  flags_t            c_flg;
  logic              c_taken;
  logic              c_pair;

  brcc_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .op(op), .opa(opa), .opb(opb), .cf_in(cf_in),
    .res(c_res), .res_wr(c_wr), .flg(c_flg)
  );

  brcc_cond_eval u_cond (
    .flg(c_flg), .cc(cc), .taken(c_taken)
  );

  brcc_pair_table u_pair (
    .op(op), .fam(cc[3:1]), .pair_ok(c_pair)
  );

  // next-state
  logic              cap_en;
  logic [DATA_W-1:0] res_d;
  logic              wr_d, taken_d, pair_d;
  flags_t            flg_d;
  flags_t            flg_q;

  always_comb begin
    cap_en  = in_valid;
    res_d   = c_res;
    wr_d    = c_wr;
    taken_d = c_taken;
    pair_d  = c_pair;
    flg_d   = c_flg;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_wr    <= 1'b0;
      br_taken  <= 1'b0;
      fuse_ok   <= 1'b0;
      flg_q     <= '0;
    end else begin
      out_valid <= cap_en;
      if (cap_en) begin
        res      <= res_d;
        res_wr   <= wr_d;
        br_taken <= taken_d;
        fuse_ok  <= pair_d;
        flg_q    <= flg_d;
      end
    end
  end

  assign cf_o = flg_q.cf;
  assign zf_o = flg_q.zf;
  assign sf_o = flg_q.sf;
  assign of_o = flg_q.of;
  assign pf_o = flg_q.pf;
endmodule

// File: rtl/brcc_fuse_chk.sv
module brcc_fuse_chk
  import brcc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [3:0]        cc,
  input logic              cf_in,
  input logic              out_valid,
  input logic              fuse_ok,
  input logic              br_taken,
  input logic [DATA_W-1:0] res,
  input logic              res_wr,
  input logic              cf_o,
  input logic              zf_o,
  input logic              sf_o,
  input logic              of_o,
  input logic              pf_o
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res)));

  p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OPC_TEST || op == OPC_CMP)) |=> !res_wr);

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zf_o == (res == '0)));

  p_sign_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sf_o == res[DATA_W-1]));

  p_parity_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pf_o == ~^res[7:0]));

  p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= OPC_XOR) |=> (!cf_o && !of_o));

  p_keep_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OPC_INC || op == OPC_DEC)) |=> (cf_o == $past(cf_in)));

  p_sign_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cc == {FAM_SIGN, 1'b0}) |=> (br_taken == sf_o));

  p_zero_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cc == {FAM_ZERO, 1'b0}) |=> (br_taken == zf_o));

  p_neg_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cc == {FAM_SIGN, 1'b1}) |=> (br_taken == !sf_o));

  p_orxor_nopair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OPC_OR || op == OPC_XOR)) |=> !fuse_ok);

  p_step_families_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OPC_INC || op == OPC_DEC) &&
     (cc[3:1] == FAM_OVF || cc[3:1] == FAM_SIGN || cc[3:1] == FAM_PAR)) |=> !fuse_ok);

  p_unassigned_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OPC_DEC) |=> (!fuse_ok && !res_wr && !cf_o && !of_o));
endmodule

bind brcc_fuse_unit brcc_fuse_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .op(op), .cc(cc),
  .cf_in(cf_in), .out_valid(out_valid), .fuse_ok(fuse_ok),
  .br_taken(br_taken), .res(res), .res_wr(res_wr), .cf_o(cf_o),
  .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .pf_o(pf_o)
);

// File: tb/brcc_fuse_unit_test.sv
module brcc_fuse_unit_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [3:0]   op, cc;
  logic [W-1:0] opa, opb;
  logic         cf_in;
  logic         out_valid, fuse_ok, br_taken, res_wr;
  logic [W-1:0] res;
  logic         cf_o, zf_o, sf_o, of_o, pf_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  brcc_fuse_unit #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cc(cc),
    .opa(opa), .opb(opb), .cf_in(cf_in), .out_valid(out_valid),
    .fuse_ok(fuse_ok), .br_taken(br_taken), .res(res), .res_wr(res_wr),
    .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .pf_o(pf_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected model from the requirements
  typedef struct {
    logic [W-1:0] r;
    logic wr, c, z, s, o, p;
  } exp_t;

  function automatic exp_t model(input logic [3:0] f_op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic ci);
    exp_t e;
    int ua, ub, sa, sb, sr;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    e.r = '0; e.wr = 1'b0; e.c = 1'b0; e.o = 1'b0;
    if (f_op == 4'd7 || f_op == 4'd8) begin ub = 1; sb = 1; end
    case (f_op)
      4'd0: e.r = a & b;
      4'd1: begin e.r = a & b; e.wr = 1; end
      4'd2: begin e.r = a | b; e.wr = 1; end
      4'd3: begin e.r = a ^ b; e.wr = 1; end
      4'd4, 4'd6, 4'd8: begin
        e.r = W'(ua - ub);
        e.wr = (f_op != 4'd4);
        e.c = (f_op == 4'd8) ? ci : (ua < ub);
        sr = sa - sb;
        e.o = (sr > 32767) || (sr < -32768);
      end
      4'd5, 4'd7: begin
        e.r = W'(ua + ub);
        e.wr = 1;
        e.c = (f_op == 4'd7) ? ci : ((ua + ub) > 65535);
        sr = sa + sb;
        e.o = (sr > 32767) || (sr < -32768);
      end
      default: e.r = '0;
    endcase
    e.z = (e.r == 0);
    e.s = e.r[W-1];
    e.p = ($countones(e.r[7:0]) % 2) == 0;
    return e;
  endfunction

  function automatic logic cond_exp(input logic [3:0] c, input exp_t e);
    logic t;
    case (c[3:1])
      3'd0: t = e.o;
      3'd1: t = e.c;
      3'd2: t = e.z;
      3'd3: t = e.c | e.z;
      3'd4: t = e.s;
      3'd5: t = e.p;
      3'd6: t = e.s ^ e.o;
      default: t = (e.s ^ e.o) | e.z;
    endcase
    return t ^ c[0];
  endfunction

  function automatic logic pair_exp(input logic [3:0] o, input logic [2:0] f);
    case (o)
      4'd0, 4'd1: return 1'b1;
      4'd4, 4'd5, 4'd6: return (f == 1 || f == 2 || f == 3 || f == 6 || f == 7);
      4'd7, 4'd8: return (f == 2 || f == 6 || f == 7);
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [3:0] c,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    op = o; cc = c; opa = a; opb = b; cf_in = ci; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic vec(input string req, input logic [3:0] o, input logic [3:0] c,
                     input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    exp_t e;
    e = model(o, a, b, ci);
    apply(o, c, a, b, ci);
    chk(req, "out_valid R2", 32'(out_valid), 32'd1);
    chk(req, "res R3", 32'(res), 32'(e.r));
    chk(req, "res_wr R3", 32'(res_wr), 32'(e.wr));
    chk(req, "zf R4", 32'(zf_o), 32'(e.z));
    chk(req, "sf R4", 32'(sf_o), 32'(e.s));
    chk(req, "pf R4", 32'(pf_o), 32'(e.p));
    chk(req, "cf", 32'(cf_o), 32'(e.c));
    chk(req, "of", 32'(of_o), 32'(e.o));
    chk(req, "taken R8", 32'(br_taken), 32'(cond_exp(c, e)));
    chk(req, "pair", 32'(fuse_ok), 32'(pair_exp(o, c[3:1])));
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "res", 32'(res), 0);
    chk("R1", "fuse_ok", 32'(fuse_ok), 0);
    chk("R1", "br_taken", 32'(br_taken), 0);
    chk("R1", "flags", 32'({cf_o, zf_o, sf_o, of_o, pf_o, res_wr}), 0);
  endtask

  task automatic t_add();
    vec("R5 add signed overflow", 4'd5, 4'd0, 16'h7FFF, 16'h0001, 1'b0);
    vec("R5 add carry wrap", 4'd5, 4'd2, 16'hFFFF, 16'h0001, 1'b0);
    vec("R5 add plain", 4'd5, 4'd3, 16'h1234, 16'h0101, 1'b1);
    vec("R5 add neg overflow", 4'd5, 4'd1, 16'h8000, 16'h8000, 1'b0);
  endtask

  task automatic t_sub();
    vec("R5 cmp equal", 4'd4, 4'd4, 16'h0005, 16'h0005, 1'b0);
    vec("R5 sub borrow", 4'd6, 4'd2, 16'h0000, 16'h0001, 1'b0);
    vec("R5 sub overflow", 4'd6, 4'd12, 16'h8000, 16'h0001, 1'b0);
  endtask

  task automatic t_logic();
    vec("R6 and cf_in set", 4'd1, 4'd3, 16'hF0F0, 16'hFF00, 1'b1);
    vec("R6 or", 4'd2, 4'd0, 16'h8001, 16'h0002, 1'b1);
    vec("R6 xor", 4'd3, 4'd8, 16'hAAAA, 16'h5555, 1'b1);
    vec("R4 parity low byte only", 4'd0, 4'd10, 16'h0100, 16'h0100, 1'b1);
  endtask

  task automatic t_step();
    vec("R7 inc wrap keeps cf 0", 4'd7, 4'd4, 16'hFFFF, 16'h1234, 1'b0);
    vec("R7 dec overflow keeps cf 1", 4'd8, 4'd0, 16'h8000, 16'h0000, 1'b1);
    vec("R7 inc overflow", 4'd7, 4'd13, 16'h7FFF, 16'h0000, 1'b1);
  endtask

  task automatic t_conds();
    logic [W-1:0] av[4] = '{16'h0003, 16'h0005, 16'h0005, 16'h8000};
    logic [W-1:0] bv[4] = '{16'h0005, 16'h0003, 16'h0005, 16'h0001};
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 16; c++)
        vec("R8 R9 condition sweep", 4'd4, 4'(c), av[i], bv[i], 1'b0);
  endtask

  task automatic t_pair();
    for (int o = 0; o < 16; o++)
      for (int c = 0; c < 16; c++) begin
        apply(4'(o), 4'(c), 16'h00F0, 16'h0F0F, 1'b1);
        if (o < 2)      chk("R10", "fuse_ok", 32'(fuse_ok), 32'(pair_exp(4'(o), 3'(c >> 1))));
        else if (o < 4) chk("R11", "fuse_ok", 32'(fuse_ok), 32'(pair_exp(4'(o), 3'(c >> 1))));
        else if (o < 7) chk("R12", "fuse_ok", 32'(fuse_ok), 32'(pair_exp(4'(o), 3'(c >> 1))));
        else if (o < 9) chk("R13", "fuse_ok", 32'(fuse_ok), 32'(pair_exp(4'(o), 3'(c >> 1))));
        else            chk("R14", "fuse_ok", 32'(fuse_ok), 32'(pair_exp(4'(o), 3'(c >> 1))));
      end
  endtask

  task automatic t_unassigned();
    vec("R14 code 12", 4'd12, 4'd5, 16'hFFFF, 16'hFFFF, 1'b1);
    vec("R14 code 15", 4'd15, 4'd4, 16'h1234, 16'h4321, 1'b1);
  endtask

  task automatic t_hold();
    logic [W-1:0] keep;
    vec("R2 capture", 4'd5, 4'd2, 16'h0100, 16'h0023, 1'b0);
    keep = res;
    op = 4'd3; opa = 16'hFFFF; opb = 16'h0000; cc = 4'd5;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 0);
    chk("R2", "res held", 32'(res), 32'(keep));
    chk("R2", "zf held", 32'(zf_o), 0);
    chk("R2", "res_wr held", 32'(res_wr), 1);
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; cc = '0;
    opa = '0; opb = '0; cf_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_add();
    t_sub();
    t_logic();
    t_step();
    t_conds();
    t_pair();
    t_unassigned();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule